// File: doc/BRIEF.md
# Two-Channel Serial Audio Receive Status Unit

This block sits behind the serial audio receiver of a larger chip. Each time the shift logic finishes capturing a word, it offers that word on a one-cycle strobe together with a one-bit channel tag. The block parks the word in a per-channel store, keeps per-channel status flags, and raises one level-sensitive interrupt line. Each store is either a single holding register or a four-word first-in first-out queue, chosen per channel. The core reaches the block through a small register port. Reading a data address returns the oldest unread word of that channel and removes it. Reading the status address has no side effect. Writing the status address clears the sticky overrun flags.

Channel 1 takes part only while two-channel operation is selected. A word that arrives for a channel whose store is already full is dropped, the stored words are kept as they are, and a sticky overrun flag is raised. For each channel the receive interrupt follows the ready flag in holding-register mode and the queue-full flag in queue mode.

Top module: `audio_rx_status`

## Requirements
- R1: A word accepted on `wd_valid` is stored for the channel given by `wd_chan` (0 or 1) and sets that channel's ready flag on the next cycle. The register map is: address 0 is the channel 0 data, address 1 is the channel 1 data, and address 2 is the status. The status bits are: bit 0 ready0, bit 1 ready1, bit 2 full0, bit 3 full1, bit 4 overrun0, bit 5 overrun1. All other bits read as 0.
- R2: With the queue off (`fifo_en[c]`=0), a read of the channel's data address returns the stored word and clears ready. If a read and a new word for the same channel land in the same cycle, the new word is kept and ready stays set.
- R3: With the queue on, up to 4 words are held and read back oldest first. The full bit is 1 exactly when 4 words are held. Ready stays set until the last word has been read.
- R4: A word that arrives while the destination is full is dropped and sets that channel's overrun flag. The destination is full when ready is set with the queue off, or when 4 words are held with the queue on. The stored words are unchanged.
- R5: An overrun flag stays set until a register write to address 2 has a 1 in its bit (bit 4 or bit 5), or until a reset. Writing 0 to the bit leaves the flag set, and so does dropping `rx_en`. If a new overrun and a clear happen in the same cycle, the flag stays set.
- R6: While `two_ch` is 0, words tagged for channel 1 are ignored, reads of address 1 remove nothing, and status bits 1, 3 and 5 read 0.
- R7: The interrupt for channel c's data needs both `rx_ie` and `rdy_ie[c]`. The source is the ready flag with the queue off and the full bit with the queue on.
- R8: The interrupt for channel c's overrun is asserted while `rx_ie`, `ovr_ie[c]` and that overrun flag are all set. `irq` is the level OR of all channel terms.
- R9: A low `rst_n` at a clock edge, or a high `soft_clr`, empties both stores and clears all flags and `irq` by the next cycle.
- R10: While `rx_en` is 0, strobed words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Synchronous block clear, active high |
| rx_en | input | 1 | Receiver enable; words are accepted only while high |
| two_ch | input | 1 | Selects two-channel operation (enables channel 1) |
| fifo_en | input | 2 | Per-channel queue enable |
| rx_ie | input | 1 | Global receive interrupt enable |
| rdy_ie | input | 2 | Per-channel data interrupt enable |
| ovr_ie | input | 2 | Per-channel overrun interrupt enable |
| wd_valid | input | 1 | One-cycle strobe: a completed word is on `wd_data` |
| wd_chan | input | 1 | Channel tag of the completed word |
| wd_data | input | DATA_W | Completed word |
| reg_addr | input | 2 | Register address (0, 1 or 2) |
| reg_rd | input | 1 | Read strobe; a data read removes one word |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions assume that `fifo_en` only changes while the affected store is empty, and that the configuration inputs are otherwise held steady around the traffic. The bench therefore changes `fifo_en` and `two_ch` only when the bench's own model shows the stores concerned to be empty, or holding words that are meant to reappear later. The assertions also assume that `wd_valid`, `reg_rd` and `reg_wr` are single-cycle strobes sampled at the clock edge. The bench drives every input at the falling edge, so each strobe lasts exactly one rising edge. A word tagged for channel 1 while `two_ch` is low is legal input, and the checker treats it as a word that must be ignored.

// File: rtl/audio_rx_pkg.sv
// Package: shared constants for the two-channel receive status unit.
// Assumes: register addresses are 2 bits wide and the register port is 32 bits wide.
package audio_rx_pkg;
    localparam int NUM_CH = 2;
    localparam int REG_W  = 32;

    localparam logic [1:0] ADDR_CH0  = 2'd0;
    localparam logic [1:0] ADDR_CH1  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // Status bit positions; the bench and the core software decode these.
    localparam int ST_RDY  = 0;   // ready flags at bits 0..1
    localparam int ST_FULL = 2;   // queue-full flags at bits 2..3
    localparam int ST_OVR  = 4;   // overrun flags at bits 4..5

    typedef struct packed {
        logic [NUM_CH-1:0] ovr;
        logic [NUM_CH-1:0] full;
        logic [NUM_CH-1:0] rdy;
    } stat_t;
endpackage

// File: rtl/rx_chan_store.sv
// Module: rx_chan_store
// Holds the received words of one channel. The storage is a ring of DEPTH
// entries. When the queue is off, the capacity is one word, so the ring acts as
// a holding register. The module reports ready, queue-full and destination-full,
// and it flags a dropped word.
// Assumes: fifo_en only changes while the store is empty. A pop and a push in
// the same cycle let the push through even when the store is full.
module rx_chan_store #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fifo_en,
    input  logic              push,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              rdy,
    output logic              fifo_full,
    output logic              dest_full,
    output logic              drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cap;
    logic              pop, take;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    // Work out the capacity, the full state and what happens to this cycle's request.
    always_comb begin
        cap       = fifo_en ? DEPTH_C : ONE_C;
        dest_full = (cnt == cap);
        pop       = pop_req && (cnt != '0);
        take      = push && (!dest_full || pop);
        drop      = push && dest_full && !pop;
        rdy       = (cnt != '0);
        fifo_full = fifo_en && (cnt == DEPTH_C);
        dout      = mem[rd_ptr];
    end

    // Write an accepted word into the ring.
    always_ff @(posedge clk) begin
        if (take) begin
            mem[wr_ptr] <= din;
        end
    end

    // Move the pointers and the word count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (take) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({take, pop})
                2'b10:   cnt <= cnt + ONE_C;
                2'b01:   cnt <= cnt - ONE_C;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/rx_ovr_flag.sv
// Module: rx_ovr_flag
// Sticky overrun flag with write-one-to-clear. A new overrun wins over a clear
// in the same cycle.
// Assumes: set and w1c are single-cycle pulses.
module rx_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    input  logic w1c,
    output logic flag
);
    // Hold the flag until it is cleared by a write or a reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (w1c) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_irq_merge.sv
// Module: rx_irq_merge
// Builds the level interrupt from the per-channel flags. A channel's data term
// uses the ready flag with the queue off and the full flag with the queue on.
// Assumes: the flags given are already masked for inactive channels.
module rx_irq_merge #(
    parameter int NUM_CH = 2
) (
    input  logic              rx_ie,
    input  logic [NUM_CH-1:0] rdy_ie,
    input  logic [NUM_CH-1:0] ovr_ie,
    input  logic [NUM_CH-1:0] fifo_en,
    input  logic [NUM_CH-1:0] rdy,
    input  logic [NUM_CH-1:0] full,
    input  logic [NUM_CH-1:0] ovr,
    output logic              irq
);
    logic [NUM_CH-1:0] term;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_term
        logic data_src;
        // Pick the data source for this channel.
        assign data_src = fifo_en[c] ? full[c] : rdy[c];
        // Combine the data term and the overrun term for this channel.
        assign term[c] = (rdy_ie[c] && data_src) || (ovr_ie[c] && ovr[c]);
    end

    // Gate every term with the global enable.
    assign irq = rx_ie && (|term);
endmodule

// File: rtl/audio_rx_status.sv
// Module: audio_rx_status (top)
// Receive data and status unit for two audio channels. It stores completed
// words per channel, keeps ready, full and overrun flags, decodes a three-address
// register port and drives a level interrupt.
// Assumes: wd_valid, reg_rd and reg_wr are single-cycle strobes; fifo_en
// changes only while the affected store is empty; DATA_W <= 32.
module audio_rx_status
    import audio_rx_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              rx_en,
    input  logic              two_ch,
    input  logic [1:0]        fifo_en,
    input  logic              rx_ie,
    input  logic [1:0]        rdy_ie,
    input  logic [1:0]        ovr_ie,
    input  logic              wd_valid,
    input  logic              wd_chan,
    input  logic [DATA_W-1:0] wd_data,
    input  logic [1:0]        reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    logic [NUM_CH-1:0] chan_act;
    logic [NUM_CH-1:0] push_ch, pop_ch, w1c;
    logic [NUM_CH-1:0] rdy_raw, full_raw, dest_full, drop_ch, ovr_raw;
    logic [NUM_CH-1:0] rdy_vis, full_vis, ovr_vis;
    logic [DATA_W-1:0] dout [NUM_CH];
    stat_t             stat;

    // Channel 0 is always active; channel 1 only in two-channel operation.
    assign chan_act = {two_ch, 1'b1};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [1:0] DATA_ADDR = 2'(c);

        // Steer strobes to this channel.
        assign push_ch[c] = wd_valid && rx_en && chan_act[c] && (wd_chan == 1'(c));
        assign pop_ch[c]  = reg_rd && chan_act[c] && (reg_addr == DATA_ADDR);
        assign w1c[c]     = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[ST_OVR + c];

        rx_chan_store #(
            .DATA_W (DATA_W),
            .DEPTH  (FIFO_DEPTH)
        ) u_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (soft_clr),
            .fifo_en   (fifo_en[c]),
            .push      (push_ch[c]),
            .pop_req   (pop_ch[c]),
            .din       (wd_data),
            .dout      (dout[c]),
            .rdy       (rdy_raw[c]),
            .fifo_full (full_raw[c]),
            .dest_full (dest_full[c]),
            .drop      (drop_ch[c])
        );

        rx_ovr_flag u_ovr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (soft_clr),
            .set   (drop_ch[c]),
            .w1c   (w1c[c]),
            .flag  (ovr_raw[c])
        );

        // Hide the flags of an inactive channel.
        assign rdy_vis[c]  = rdy_raw[c]  && chan_act[c];
        assign full_vis[c] = full_raw[c] && chan_act[c];
        assign ovr_vis[c]  = ovr_raw[c]  && chan_act[c];
    end

    // Pack the status word.
    always_comb begin
        stat.rdy  = rdy_vis;
        stat.full = full_vis;
        stat.ovr  = ovr_vis;
    end

    // Return the addressed register on the read bus.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CH0:  reg_rdata[DATA_W-1:0] = dout[0];
            ADDR_CH1:  reg_rdata[DATA_W-1:0] = dout[1];
            ADDR_STAT: reg_rdata[$bits(stat_t)-1:0] = stat;
            default:   reg_rdata = '0;
        endcase
    end

    rx_irq_merge #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .rx_ie   (rx_ie),
        .rdy_ie  (rdy_ie),
        .ovr_ie  (ovr_ie),
        .fifo_en (fifo_en),
        .rdy     (rdy_vis),
        .full    (full_vis),
        .ovr     (ovr_vis),
        .irq     (irq)
    );
endmodule

// File: rtl/audio_rx_status_chk.sv
// Module: audio_rx_status_chk
// Property checker bound to audio_rx_status. It checks the flags against the
// strobes over time.
// Assumes: the same input rules as the top module.
module audio_rx_status_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_clr,
    input logic              two_ch,
    input logic              rx_ie,
    input logic [1:0]        ovr_ie,
    input logic              irq,
    input logic [1:0]        push_ch,
    input logic [1:0]        pop_ch,
    input logic [1:0]        w1c,
    input logic [1:0]        dest_full,
    input logic [1:0]        rdy_raw,
    input logic [1:0]        full_raw,
    input logic [1:0]        ovr_raw,
    input logic [1:0]        rdy_vis,
    input logic [1:0]        ovr_vis,
    input logic [DATA_W-1:0] dout0
);
    // R1: an accepted word leaves the channel ready
    a_r1_rdy_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_ch[0] && !soft_clr |=> rdy_raw[0]);

    // R3: a full queue always holds data
    a_r3_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        full_raw[0] |-> rdy_raw[0]);

    // R4: a word into a full store sets overrun
    a_r4_ovr_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        push_ch[0] && dest_full[0] && !pop_ch[0] && !soft_clr |=> ovr_raw[0]);

    // R4: a dropped word leaves the stored head untouched
    a_r4_head_kept: assert property (@(posedge clk) disable iff (!rst_n)
        push_ch[0] && dest_full[0] && !pop_ch[0] && !soft_clr |=> dout0 == $past(dout0));

    // R5: overrun is sticky without a clear
    a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_raw[0] && !w1c[0] && !soft_clr |=> ovr_raw[0]);

    // R6: channel 1 status is quiet in single-channel operation
    a_r6_ch1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !two_ch |-> !rdy_vis[1] && !ovr_vis[1]);

    // R8: an enabled overrun drives the interrupt
    a_r8_irq_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ie && ovr_ie[0] && ovr_vis[0] |-> irq);

    // R9: a block clear empties the store and the flags
    a_r9_soft_clr: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> !rdy_raw[0] && !ovr_raw[0] && !rdy_raw[1] && !ovr_raw[1]);
endmodule

bind audio_rx_status audio_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (soft_clr),
    .two_ch    (two_ch),
    .rx_ie     (rx_ie),
    .ovr_ie    (ovr_ie),
    .irq       (irq),
    .push_ch   (push_ch),
    .pop_ch    (pop_ch),
    .w1c       (w1c),
    .dest_full (dest_full),
    .rdy_raw   (rdy_raw),
    .full_raw  (full_raw),
    .ovr_raw   (ovr_raw),
    .rdy_vis   (rdy_vis),
    .ovr_vis   (ovr_vis),
    .dout0     (dout[0])
);

// File: tb/audio_rx_status_bench.sv
`timescale 1ns/1ps
// Bench for audio_rx_status: a behavioural queue model is updated at every
// rising edge, and the status word and irq are compared at every falling edge.
module audio_rx_status_bench;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_clr = 1'b0;
    logic          rx_en = 1'b1;
    logic          two_ch = 1'b1;
    logic [1:0]    fifo_en = 2'b00;
    logic          rx_ie = 1'b0;
    logic [1:0]    rdy_ie = 2'b00;
    logic [1:0]    ovr_ie = 2'b00;
    logic          wd_valid = 1'b0;
    logic          wd_chan = 1'b0;
    logic [DW-1:0] wd_data = '0;
    logic [1:0]    reg_addr = 2'd2;
    logic          reg_rd = 1'b0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_req = "R9";

    int unsigned q0[$];
    int unsigned q1[$];
    bit          ovr_m [2];

    always #2.5 clk = ~clk;

    audio_rx_status #(.DATA_W(DW), .FIFO_DEPTH(4)) u_audio_rx_status (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .rx_en(rx_en),
        .two_ch(two_ch), .fifo_en(fifo_en), .rx_ie(rx_ie), .rdy_ie(rdy_ie),
        .ovr_ie(ovr_ie), .wd_valid(wd_valid), .wd_chan(wd_chan), .wd_data(wd_data),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int qsize(input int c);
        return (c == 0) ? q0.size() : q1.size();
    endfunction

    function automatic bit active(input int c);
        return (c == 0) || two_ch;
    endfunction

    // Expected status word from the model.
    function automatic int unsigned exp_status();
        int unsigned s = 0;
        for (int c = 0; c < 2; c++) begin
            if (active(c)) begin
                if (qsize(c) > 0) s |= (1 << c);
                if (fifo_en[c] && qsize(c) == 4) s |= (1 << (2 + c));
                if (ovr_m[c]) s |= (1 << (4 + c));
            end
        end
        return s;
    endfunction

    function automatic bit exp_irq();
        int unsigned s = exp_status();
        bit r = 0;
        for (int c = 0; c < 2; c++) begin
            bit src = fifo_en[c] ? s[2 + c] : s[c];
            if (rdy_ie[c] && src) r = 1;
            if (ovr_ie[c] && s[4 + c]) r = 1;
        end
        return rx_ie && r;
    endfunction

    // Model update at a rising edge, from the inputs the bench holds.
    task automatic model_edge();
        if (!rst_n || soft_clr) begin
            q0.delete(); q1.delete();
            ovr_m[0] = 0; ovr_m[1] = 0;
            return;
        end
        for (int c = 0; c < 2; c++) begin
            bit push = wd_valid && rx_en && active(c) && (wd_chan == c[0]);
            bit pop  = reg_rd && active(c) && (reg_addr == c[1:0]) && (qsize(c) > 0);
            int cap  = fifo_en[c] ? 4 : 1;
            bit set  = 0;
            if (push && qsize(c) == cap && !pop) begin
                set = 1;
            end else begin
                if (c == 0) begin
                    if (pop) void'(q0.pop_front());
                    if (push) q0.push_back(int'(wd_data));
                end else begin
                    if (pop) void'(q1.pop_front());
                    if (push) q1.push_back(int'(wd_data));
                end
            end
            if (set) ovr_m[c] = 1;
            else if (reg_wr && reg_addr == 2'd2 && reg_wdata[4 + c]) ovr_m[c] = 0;
        end
    endtask

    // One clock: apply strobes, check read data, update model, compare status and irq.
    task automatic cyc(input bit v, input bit ch, input int unsigned d,
                       input bit rd, input bit wr, input logic [1:0] a, input int unsigned wdat);
        wd_valid = v; wd_chan = ch; wd_data = d[DW-1:0];
        reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wdat;
        #1;
        if (rd && a < 2 && active(int'(a)) && qsize(int'(a)) > 0)
            check(cur_req, "read data", reg_rdata, (a == 0) ? q0[0] : q1[0]);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wd_valid = 0; reg_rd = 0; reg_wr = 0; reg_addr = 2'd2; reg_wdata = 0;
        #1;
        check(cur_req, "status", reg_rdata, exp_status());
        check(cur_req, "irq", irq, exp_irq());
    endtask

    task automatic push(input bit ch, input int unsigned d);
        cyc(1, ch, d, 0, 0, 2'd2, 0);
    endtask
    task automatic rd(input logic [1:0] a);
        cyc(0, 0, 0, 1, 0, a, 0);
    endtask
    task automatic wr_stat(input int unsigned w);
        cyc(0, 0, 0, 0, 1, 2'd2, w);
    endtask
    task automatic idle();
        cyc(0, 0, 0, 0, 0, 2'd2, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 0;
        @(posedge clk); model_edge();
        @(posedge clk); model_edge();
        @(negedge clk);
        rst_n = 1;
        cur_req = "R9"; idle();                       // R9 reset state
        check("R9", "reset status", reg_rdata, 0);

        // R1: load sets ready, data readable at address 0 and 1
        cur_req = "R1";
        push(0, 24'h1A2B3C);
        check("R1", "rdy0 bit0", reg_rdata[0], 1);
        push(1, 24'h445566);
        check("R1", "rdy1 bit1", reg_rdata[1], 1);
        // R2: read clears ready with the queue off
        cur_req = "R2";
        rd(2'd0);
        check("R2", "rdy0 cleared", reg_rdata[0], 0);
        rd(2'd1);
        push(0, 24'h000011);
        cyc(1, 0, 24'h000022, 1, 0, 2'd0, 0);         // R2 read and load together
        check("R2", "rdy0 stays", reg_rdata[0], 1);
        reg_addr = 2'd0; #1;
        check("R2", "new word kept", reg_rdata, 24'h22);

        // R4: overrun drops the word, keeps data; R8 irq on overrun
        cur_req = "R4";
        ovr_ie = 2'b01; rx_ie = 1;
        push(0, 24'h0000EE);
        check("R4", "ovr0 bit4", reg_rdata[4], 1);
        check("R8", "irq on overrun", irq, 1);
        reg_addr = 2'd0; #1;
        check("R4", "data unchanged", reg_rdata, 24'h22);

        // R5: sticky across rx_en low and a write of 0; W1C clears
        cur_req = "R5";
        rx_en = 0; idle(); rx_en = 1;
        wr_stat(32'h0000_0020);
        check("R5", "ovr0 after write 0", reg_rdata[4], 1);
        cyc(1, 0, 24'h33, 0, 1, 2'd2, 32'h10);        // new overrun beats clear
        check("R5", "set wins clear", reg_rdata[4], 1);
        wr_stat(32'h0000_0010);
        check("R5", "ovr0 cleared", reg_rdata[4], 0);
        ovr_ie = 0; rx_ie = 0;
        rd(2'd0);

        // R3 and R7: queue on channel 1, interrupt follows full
        cur_req = "R3";
        fifo_en = 2'b10; rx_ie = 1; rdy_ie = 2'b10;
        for (int i = 0; i < 3; i++) push(1, 24'h100 + i);
        check("R7", "no irq below full", irq, 0);
        push(1, 24'h103);
        check("R3", "full1 bit3", reg_rdata[3], 1);
        check("R7", "irq on full", irq, 1);
        push(1, 24'h1FF);                             // R4 queue overrun
        check("R4", "ovr1 bit5", reg_rdata[5], 1);
        rx_ie = 0; idle();
        check("R7", "irq gated by global", irq, 0);
        rx_ie = 1;
        for (int i = 0; i < 4; i++) rd(2'd1);         // R3 order via read checks
        check("R3", "rdy1 after drain", reg_rdata[1], 0);
        wr_stat(32'h20);
        // R7: queue off uses ready
        cur_req = "R7";
        fifo_en = 2'b00; rdy_ie = 2'b01;
        push(0, 24'h77);
        check("R7", "irq on ready", irq, 1);
        rd(2'd0);
        rx_ie = 0; rdy_ie = 0;

        // R6: single-channel mode ignores channel 1
        cur_req = "R6";
        push(1, 24'h55);
        two_ch = 0;
        idle();
        check("R6", "ch1 bits hidden", reg_rdata[5:0] & 6'h2A, 0);
        push(1, 24'h66);
        rd(2'd1);
        two_ch = 1; idle();
        check("R6", "ch1 word intact", reg_rdata[1], 1);
        rd(2'd1);

        // R10: receiver disabled ignores words
        cur_req = "R10";
        rx_en = 0;
        push(0, 24'h99);
        check("R10", "no rdy0", reg_rdata[0], 0);
        rx_en = 1;

        // R9: soft clear
        cur_req = "R9";
        fifo_en = 2'b11;
        push(0, 1); push(1, 2); push(0, 3);
        soft_clr = 1; idle(); soft_clr = 0;
        check("R9", "status after soft clear", reg_rdata, 0);
        idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule